// File: doc/BRIEF.md
# External Memory Read Sequencer

This block carries out single read transfers on an asynchronous external memory bus for an on-chip requester. A request carries a 19-bit address. The sequencer accepts it with a combinational acknowledge, and then runs the bus through three timed stages: set-up, strobe and hold-off. The length of each stage is a programmable number of timing-clock cycles. During the strobe stage the active-low read strobe is asserted. The 16-bit data bus is captured on the last strobe cycle and returned to the requester with a single-cycle valid pulse.

The bus clock it drives runs at the timing-clock rate or at half that rate. In half-rate mode every transfer must begin while the bus clock is in its high half. When the request arrives in the wrong half, the sequencer inserts one idle alignment cycle first. The address bus never floats back to a default value: between transfers, and during alignment, it keeps the last address it drove. An optional handshake lets a slow device stretch the strobe stage with a ready input. When that option is off, the ready input has no effect at all.

Top module: `ext_rd_seq`

## Requirements
- R1: After reset, chip-select, read strobe and write strobe are high (inactive), the direction line is high, the valid pulse is low and the address bus is zero.
- R2: Chip-select goes low in the first cycle of the set-up stage and stays low for exactly the programmed set-up count (minimum 1) before the read strobe falls.
- R3: With the ready option off (use_ready_i = 0), the read strobe stays low for exactly the programmed strobe count (minimum 1), whatever the level of ready_i. The read strobe is low only while chip-select is low.
- R4: After the read strobe rises, chip-select stays low for exactly the programmed hold-off count. A count of 0 makes both rise at the same edge.
- R5: rdata_o equals the value of data_i during the last cycle of the read strobe. rvalid_o is high for exactly one cycle, the first cycle in which chip-select is high again, and rdata_o is valid in that cycle.
- R6: With half_rate_i = 1, bus_clk_o toggles on every timing-clock rising edge. With half_rate_i = 0, bus_clk_o follows the timing clock.
- R7: In half-rate mode, a request accepted while bus_clk_o is high gets exactly one alignment cycle, with all strobes high, before chip-select falls. A request accepted while bus_clk_o is low gets none. Chip-select always falls into a cycle in which bus_clk_o is high. Full-rate mode never aligns.
- R8: addr_o takes the new address only in the cycle in which chip-select falls. It holds it for the whole transfer and keeps it afterwards, so alignment and idle cycles show the previous address.
- R9: With use_ready_i = 1, the strobe stage ends at the end of the first strobe cycle whose index is at least the programmed strobe count and in which ready_i is high. Until then the read strobe stays low.
- R10: ack_o equals req_i while the sequencer is idle and is 0 while a transfer is in progress.
- R11: we_n_o stays 1 and rnw_o stays 1 (1 encodes read) at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| half_rate_i | input | 1 | 1: bus clock at half the timing-clock rate |
| use_ready_i | input | 1 | 1: strobe stage may be stretched by ready_i |
| lead_len_i | input | CNT_W | Set-up stage length in cycles |
| active_len_i | input | CNT_W | Strobe stage length in cycles |
| trail_len_i | input | CNT_W | Hold-off stage length in cycles |
| req_i | input | 1 | Read request |
| req_addr_i | input | ADDR_W | Read address |
| ack_o | output | 1 | Request accepted this cycle |
| rvalid_o | output | 1 | One-cycle read data valid |
| rdata_o | output | DATA_W | Captured read data |
| bus_clk_o | output | 1 | Bus output clock |
| cs_n_o | output | 1 | Zone chip-select, active low |
| addr_o | output | ADDR_W | External address bus |
| rd_n_o | output | 1 | Read strobe, active low |
| we_n_o | output | 1 | Write strobe, held inactive |
| rnw_o | output | 1 | Direction line, 1 = read |
| data_i | input | DATA_W | External data bus |
| ready_i | input | 1 | External ready |

## Verification
The alignment cycle is the awkward case. It appears only in half-rate mode, and only when the request lands while the bus clock is high, so it depends on the clock parity at the request cycle. The directed scenario issues half-rate reads after idle gaps of zero and one cycle, so that both parities occur. It reads the bus-clock level in the acceptance cycle to predict whether an alignment cycle follows, and it confirms that each parity was hit at least once. The strobe-stretch case drives ready_i from a count of elapsed strobe cycles, so the release lands both before and after the programmed count.

// File: rtl/ers_pkg.sv
package ers_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ALIGN  = 3'd1,
      ST_LEAD   = 3'd2,
      ST_ACTIVE = 3'd3,
      ST_TRAIL  = 3'd4
   } seq_state_e;

   typedef struct packed {
      logic       use_ready;
      logic [7:0] lead;
      logic [7:0] active;
      logic [7:0] trail;
   } seq_cfg_t;

endpackage

// File: rtl/ers_busclk.sv
module ers_busclk (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic half_rate_i,
   output logic half_hi_o,
   output logic bus_clk_o
);

   logic half_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) half_q <= 1'b0;
      else         half_q <= ~half_q;
   end

   assign half_hi_o = half_q;
   assign bus_clk_o = half_rate_i ? half_q : clk_i;

endmodule

// File: rtl/ers_phase_timer.sv
module ers_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             reached_o
);

   localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CntOne = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (restart_i)      cnt_q <= CntOne;
      else if (cnt_q != CntMax) cnt_q <= cnt_q + CntOne;
   end

   assign reached_o = (cnt_q >= target_i);

endmodule

// File: rtl/ers_capture.sv
module ers_capture #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);

   localparam int NumLanes = (DATA_W + LANE_W - 1) / LANE_W;

   for (genvar g = 0; g < NumLanes; g++) begin : g_lane
      localparam int Lo = g * LANE_W;
      localparam int Hi = ((g + 1) * LANE_W > DATA_W) ? DATA_W - 1 : (g + 1) * LANE_W - 1;
      logic [Hi-Lo:0] lane_q;
      always_ff @(posedge clk_i) begin
         if (!rst_ni)     lane_q <= '0;
         else if (load_i) lane_q <= d_i[Hi:Lo];
      end
      assign q_o[Hi:Lo] = lane_q;
   end

endmodule

// File: rtl/ext_rd_seq.sv
module ext_rd_seq #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              half_rate_i,
   input  logic              use_ready_i,
   input  logic [CNT_W-1:0]  lead_len_i,
   input  logic [CNT_W-1:0]  active_len_i,
   input  logic [CNT_W-1:0]  trail_len_i,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic              ack_o,
   output logic              rvalid_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              bus_clk_o,
   output logic              cs_n_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              rd_n_o,
   output logic              we_n_o,
   output logic              rnw_o,
   input  logic [DATA_W-1:0] data_i,
   input  logic              ready_i
);
   import ers_pkg::*;

   localparam logic [CNT_W-1:0] LenOne = {{(CNT_W-1){1'b0}}, 1'b1};

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("ext_rd_seq: ADDR_W and DATA_W must be positive");
   end
   if (CNT_W < 2 || CNT_W > 8) begin : g_bad_cnt
      $error("ext_rd_seq: CNT_W must lie in 2..8");
   end

   seq_state_e        state_q, state_d;
   logic [CNT_W-1:0]  lead_q, active_q, trail_q;
   logic              use_rdy_q;
   logic [ADDR_W-1:0] pend_addr_q, addr_q;
   logic              cs_n_q, rd_n_q, rvalid_q;
   logic              half_hi, reached, restart, accept, leave_active, finish;
   logic [CNT_W-1:0]  target;

   ers_busclk u_busclk (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .half_rate_i (half_rate_i),
      .half_hi_o   (half_hi),
      .bus_clk_o   (bus_clk_o)
   );

   always_comb begin
      unique case (state_q)
         ST_LEAD:   target = lead_q;
         ST_ACTIVE: target = active_q;
         default:   target = trail_q;
      endcase
   end

   ers_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .target_i  (target),
      .reached_o (reached)
   );

   assign accept       = (state_q == ST_IDLE) && req_i;
   assign leave_active = (state_q == ST_ACTIVE) && reached && (!use_rdy_q || ready_i);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (req_i) state_d = (half_rate_i && half_hi) ? ST_ALIGN : ST_LEAD;
         ST_ALIGN:  state_d = ST_LEAD;
         ST_LEAD:   if (reached) state_d = ST_ACTIVE;
         ST_ACTIVE: if (leave_active) state_d = (trail_q == '0) ? ST_IDLE : ST_TRAIL;
         ST_TRAIL:  if (reached) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   assign restart = (state_d != state_q);
   assign finish  = (state_q != ST_IDLE) && (state_d == ST_IDLE);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q     <= ST_IDLE;
         lead_q      <= LenOne;
         active_q    <= LenOne;
         trail_q     <= '0;
         use_rdy_q   <= 1'b0;
         pend_addr_q <= '0;
         addr_q      <= '0;
         cs_n_q      <= 1'b1;
         rd_n_q      <= 1'b1;
         rvalid_q    <= 1'b0;
      end else begin
         state_q  <= state_d;
         cs_n_q   <= !(state_d == ST_LEAD || state_d == ST_ACTIVE || state_d == ST_TRAIL);
         rd_n_q   <= (state_d != ST_ACTIVE);
         rvalid_q <= finish;
         if (accept) begin
            lead_q      <= (lead_len_i == '0)   ? LenOne : lead_len_i;
            active_q    <= (active_len_i == '0) ? LenOne : active_len_i;
            trail_q     <= trail_len_i;
            use_rdy_q   <= use_ready_i;
            pend_addr_q <= req_addr_i;
         end
         if (state_d == ST_LEAD && state_q != ST_LEAD)
            addr_q <= (state_q == ST_IDLE) ? req_addr_i : pend_addr_q;
      end
   end

   ers_capture #(.DATA_W(DATA_W)) u_capture (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (leave_active),
      .d_i    (data_i),
      .q_o    (rdata_o)
   );

   assign ack_o    = accept;
   assign rvalid_o = rvalid_q;
   assign cs_n_o   = cs_n_q;
   assign rd_n_o   = rd_n_q;
   assign addr_o   = addr_q;
   assign we_n_o   = 1'b1;
   assign rnw_o    = 1'b1;

endmodule

// File: rtl/ext_rd_seq_chk.sv
module ext_rd_seq_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              half_rate_i,
   input logic              ack_o,
   input logic              rvalid_o,
   input logic              bus_clk_o,
   input logic              cs_n_o,
   input logic              rd_n_o,
   input logic              we_n_o,
   input logic              rnw_o,
   input logic [ADDR_W-1:0] addr_o
);

   // R11
   wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) we_n_o && rnw_o);

   // R3
   rd_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !rd_n_o |-> !cs_n_o);

   // R5
   pulse_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rvalid_o |=> !rvalid_o);

   // R10
   busy_no_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !cs_n_o |-> !ack_o);

   // R8
   addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(addr_o) |-> $fell(cs_n_o));

   // R7
   lead_on_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (half_rate_i && $fell(cs_n_o)) |-> bus_clk_o);

endmodule

bind ext_rd_seq ext_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .half_rate_i (half_rate_i),
   .ack_o       (ack_o),
   .rvalid_o    (rvalid_o),
   .bus_clk_o   (bus_clk_o),
   .cs_n_o      (cs_n_o),
   .rd_n_o      (rd_n_o),
   .we_n_o      (we_n_o),
   .rnw_o       (rnw_o),
   .addr_o      (addr_o)
);

// File: tb/ext_rd_seq_tb.sv
module ext_rd_seq_tb;

   localparam int AW = 19;
   localparam int DW = 16;
   localparam int CW = 4;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          half_rate_i = 1'b0, use_ready_i = 1'b0;
   logic [CW-1:0] lead_len_i = 4'd1, active_len_i = 4'd1, trail_len_i = 4'd0;
   logic          req_i = 1'b0;
   logic [AW-1:0] req_addr_i = '0;
   logic          ack_o, rvalid_o, bus_clk_o, cs_n_o, rd_n_o, we_n_o, rnw_o;
   logic [DW-1:0] rdata_o;
   logic [AW-1:0] addr_o;
   logic [DW-1:0] data_i = 16'h1234;
   logic          ready_i = 1'b0;

   int errors = 0;
   int checks = 0;
   logic [AW-1:0] prev_addr = '0;
   int seen_align = 0, seen_noalign = 0;

   always #4 clk_i = ~clk_i;
   always @(posedge clk_i) data_i <= data_i + 16'h0137;

   ext_rd_seq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
      .clk_i, .rst_ni, .half_rate_i, .use_ready_i, .lead_len_i, .active_len_i,
      .trail_len_i, .req_i, .req_addr_i, .ack_o, .rvalid_o, .rdata_o, .bus_clk_o,
      .cs_n_o, .addr_o, .rd_n_o, .we_n_o, .rnw_o, .data_i, .ready_i
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one read; stall = strobe cycle index from which ready_i is driven high
   task automatic do_read(input logic [AW-1:0] a, input int l, input int act, input int t,
                          input bit half, input bit urdy, input int stall);
      int n_align = 0, n_lead = 0, n_rd = 0, n_trail = 0, bad_ack = 0, bad_addr = 0, bad_strb = 0;
      bit cs_seen = 0, done = 0, h;
      logic [DW-1:0] last_d = '0;
      int exp_act;
      @(negedge clk_i);
      half_rate_i = half; use_ready_i = urdy;
      lead_len_i = CW'(l); active_len_i = CW'(act); trail_len_i = CW'(t);
      req_addr_i = a; req_i = 1'b1; ready_i = 1'b0;
      #0;
      h = bus_clk_o;
      chk(ack_o == 1'b1, "R10 ack while idle", ack_o, 1);
      for (int i = 0; i < 200 && !done; i++) begin
         @(negedge clk_i);
         req_i = 1'b0;
         if (we_n_o !== 1'b1 || rnw_o !== 1'b1) bad_strb++;
         if (!cs_seen && cs_n_o) begin
            n_align++;
            if (!rd_n_o || addr_o != prev_addr) bad_strb++;
         end else if (!cs_n_o) begin
            if (!cs_seen && half && !bus_clk_o) bad_strb++;
            cs_seen = 1;
            if (addr_o != a) bad_addr++;
            if (ack_o) bad_ack++;
            if (!rd_n_o) begin
               n_rd++; last_d = data_i;
            end else if (n_rd == 0) n_lead++;
            else n_trail++;
            ready_i = urdy ? (n_rd >= stall) : 1'b0;
         end else begin
            done = 1;
            chk(rvalid_o == 1'b1, "R5 valid pulse after release", rvalid_o, 1);
            chk(rdata_o == last_d, "R5 captured data", rdata_o, last_d);
         end
      end
      exp_act = (urdy && stall > act) ? stall : act;
      chk(done, "R2 access completed", done, 1);
      chk(n_lead == l, "R2 lead length", n_lead, l);
      chk(n_rd == exp_act, urdy ? "R9 stretched strobe" : "R3 strobe length", n_rd, exp_act);
      chk(n_trail == t, "R4 trail length", n_trail, t);
      chk(n_align == ((half && h) ? 1 : 0), "R7 alignment count", n_align, (half && h) ? 1 : 0);
      chk(bad_strb == 0, "R11 R7 strobes idle", bad_strb, 0);
      chk(bad_addr == 0, "R8 address during access", bad_addr, 0);
      chk(bad_ack == 0, "R10 no ack while busy", bad_ack, 0);
      if (half && h) seen_align++;
      if (half && !h) seen_noalign++;
      @(negedge clk_i);
      chk(rvalid_o == 1'b0, "R5 single pulse", rvalid_o, 0);
      chk(addr_o == a, "R8 address held when idle", addr_o, a);
      prev_addr = a;
      ready_i = 1'b0;
   endtask

   task automatic t_reset();
      chk(cs_n_o && rd_n_o && we_n_o && rnw_o, "R1 strobes after reset",
          {cs_n_o, rd_n_o, we_n_o, rnw_o}, 4'hf);
      chk(rvalid_o == 1'b0, "R1 valid after reset", rvalid_o, 0);
      chk(addr_o == '0, "R1 address after reset", addr_o, 0);
   endtask

   task automatic t_full_rate();
      do_read(19'h0_1a2b, 1, 1, 0, 1'b0, 1'b0, 0);
      do_read(19'h7_ffff, 3, 4, 2, 1'b0, 1'b0, 0);
      do_read(19'h4_0001, 2, 5, 7, 1'b0, 1'b0, 0);
   endtask

   task automatic t_ready_ignored();
      // R3: ready low all along, option off -> strobe length unchanged
      do_read(19'h2_2222, 2, 3, 1, 1'b0, 1'b0, 9);
   endtask

   task automatic t_ready_stretch();
      do_read(19'h3_0303, 1, 2, 1, 1'b0, 1'b1, 6);
      do_read(19'h3_0404, 2, 5, 0, 1'b0, 1'b1, 2);
   endtask

   task automatic t_half_rate();
      bit a, b;
      @(negedge clk_i); half_rate_i = 1'b1;
      @(negedge clk_i); a = bus_clk_o;
      @(negedge clk_i); b = bus_clk_o;
      chk(a != b, "R6 half-rate clock toggles", b, !a);
      half_rate_i = 1'b0;
      #0 chk(bus_clk_o == 1'b0, "R6 full-rate low phase", bus_clk_o, 0);
      @(posedge clk_i); #1;
      chk(bus_clk_o == 1'b1, "R6 full-rate high phase", bus_clk_o, 1);
      for (int gap = 0; gap < 4; gap++) begin
         for (int g = 0; g < gap; g++) @(negedge clk_i);
         do_read(19'h5_0000 + 19'(gap), 1 + gap % 2, 2, gap % 3, 1'b1, 1'b0, 0);
      end
      chk(seen_align > 0, "R7 alignment case hit", seen_align, 1);
      chk(seen_noalign > 0, "R7 aligned case hit", seen_noalign, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      t_reset();
      t_full_rate();
      t_ready_ignored();
      t_ready_stretch();
      t_half_rate();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_i);
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule